// File: doc/BRIEF.md
# Load Multiple Register Sequencer

This block carries out a four-byte instruction that fills a run of consecutive 32-bit general registers from consecutive fullwords in memory. It accepts a 32-bit instruction word with a one-cycle start strobe. While idle it reads the named base register through an external register-file read port. It forms the starting byte address from that base value plus a 12-bit displacement. It then walks the register range, issuing one word read per register over a request/valid memory port with variable latency. Each returned word is written through the register-file write port into the next register of the range.

The range is given by a first and a last register number. When the last number is below the first, the range runs up to register 15 and wraps to register 0. The base value is sampled once, when the instruction is accepted, so a range that overwrites its own base register still reads the correct addresses. Only one read is in flight at any time. A done pulse marks the end of the sequence, and busy covers the whole sequence.

Top module: `multi_reg_loader`

## Requirements
- R1: An instruction is accepted only in a cycle where busy_o is low, start_i is high and instr_i[31:24] equals 0x98. Any other opcode leaves busy_o low and issues no memory request.
- R2: instr_i[23:20] is the first register and instr_i[19:16] the last. Registers are written in ascending order, one write per returned word, starting at the first register.
- R3: The number of registers loaded is ((last - first) mod 16) + 1. When last is below first, register 15 is followed by register 0. When first equals last, one register is loaded.
- R4: The first request address is the base register content (register number instr_i[15:12]) plus the zero-extended displacement instr_i[11:0], taken modulo 2^24. A base field of 0 uses no base register, so the address is the displacement alone.
- R5: Each following request address is the previous one plus 4, modulo 2^24.
- R6: The base value is sampled in the accept cycle. Later writes to that register, including writes made by the sequence itself, do not change the addresses.
- R7: mem_req_o is high for exactly one cycle per word. No new request is issued until mem_valid_i has returned data for the previous one.
- R8: The register write happens in the same cycle as mem_valid_i, with rf_wdata_o equal to mem_rdata_i.
- R9: done_o pulses for one cycle, in the cycle after the final register write. busy_o is low in that cycle and high from the cycle after accept through the final write.
- R10: A start_i pulse while busy_o is high is ignored and does not change the running sequence.
- R11: After reset, busy_o, done_o, mem_req_o and rf_we_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word (opcode, first/last register, base, displacement) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final register write |
| rf_raddr_o | output | 4 | Register-file read address (base field of instr_i) |
| rf_rdata_i | input | 32 | Register-file read data, combinational from rf_raddr_o |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | 24 | Byte address of the requested word |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The sequence is exercised with several kinds of range:
- A plain ascending range with a nonzero base, which checks the address sum and the +4 stepping.
- A zero base field over a nonzero register 0, which separates "no base" from "register 0".
- A wrapping range and a full 16-register wrap, which separate the modulo-16 walk from a simple comparison.
- A single-register range, which shows that first equal to last means one load and not sixteen.
- A range that contains its own base register and whose addresses cross the 24-bit limit, which tells a sampled base from a re-read one and checks truncation.

Random memory latencies show that requests stay single and ordered. A foreign opcode and a start issued mid-sequence both have to leave the traffic unchanged.

// File: rtl/mrl_pkg.sv
// Package: shared state encoding for the load-multiple sequencer.
// Assumes a single-cycle, single-outstanding request protocol.
package mrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/mrl_decode.sv
// mrl_decode: splits the instruction word into its fields and qualifies
// the start strobe. Assumes the opcode occupies the top byte, followed by
// the first and last register nibbles, the base nibble and the displacement.
module mrl_decode #(
    parameter int          REG_W  = 4,
    parameter int          DISP_W = 12,
    parameter logic [7:0]  OPCODE = 8'h98,
    localparam int         OP_W    = 8,
    localparam int         INSTR_W = OP_W + 3 * REG_W + DISP_W
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               start_i,
    input  logic               idle_i,
    output logic               accept_o,
    output logic [REG_W-1:0]   first_o,
    output logic [REG_W-1:0]   last_o,
    output logic [REG_W-1:0]   base_sel_o,
    output logic               base_zero_o,
    output logic [DISP_W-1:0]  disp_o
);
    localparam int OP_LSB    = INSTR_W - OP_W;
    localparam int FIRST_LSB = OP_LSB - REG_W;
    localparam int LAST_LSB  = FIRST_LSB - REG_W;
    localparam int BASE_LSB  = LAST_LSB - REG_W;

    logic [OP_W-1:0] opcode;

    // Field extraction and start qualification.
    always_comb begin
        opcode      = instr_i[OP_LSB +: OP_W];
        first_o     = instr_i[FIRST_LSB +: REG_W];
        last_o      = instr_i[LAST_LSB +: REG_W];
        base_sel_o  = instr_i[BASE_LSB +: REG_W];
        disp_o      = instr_i[0 +: DISP_W];
        base_zero_o = (base_sel_o == '0);
        accept_o    = start_i && idle_i && (opcode == OPCODE);
    end
endmodule

// File: rtl/mrl_addr_gen.sv
// mrl_addr_gen: holds the current word address. It loads base + displacement
// on accept (base ignored when the base field is zero) and steps by one word
// per advance. Assumes ADDR_W <= DATA_W and DISP_W < ADDR_W.
module mrl_addr_gen #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 24,
    parameter int DISP_W     = 12,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] base_val_i,
    input  logic              base_zero_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [DATA_W-1:0] base_eff;
    logic [DATA_W-1:0] start_full;

    // Effective base and full-width starting sum.
    always_comb begin
        base_eff   = base_zero_i ? '0 : base_val_i;
        start_full = base_eff + DATA_W'(disp_i);
    end

    // Address register: load on accept, increment on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_o <= '0;
        else if (load_i)
            addr_o <= start_full[ADDR_W-1:0];
        else if (step_i)
            addr_o <= addr_o + STEP;
    end

    // R6: the address never moves except on accept or advance.
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(addr_o));
endmodule

// File: rtl/mrl_reg_walker.sv
// mrl_reg_walker: tracks the register being loaded and the range end.
// Increments modulo 2^REG_W so a range wraps past the top register.
module mrl_reg_walker #(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [REG_W-1:0] first_i,
    input  logic [REG_W-1:0] last_i,
    input  logic             adv_i,
    output logic [REG_W-1:0] cur_o,
    output logic             final_o
);
    logic [REG_W-1:0] last_q;

    // Current and last register numbers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o  <= '0;
            last_q <= '0;
        end else if (load_i) begin
            cur_o  <= first_i;
            last_q <= last_i;
        end else if (adv_i) begin
            cur_o  <= cur_o + REG_W'(1);
        end
    end

    // End-of-range detect.
    always_comb final_o = (cur_o == last_q);

    // R2: each advance moves to the next register number.
    assert_walk_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (cur_o == REG_W'($past(cur_o) + 1)));
    // R10: the range end stays fixed unless a new instruction is accepted.
    assert_range_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(last_q));
endmodule

// File: rtl/multi_reg_loader.sv
// multi_reg_loader: top of the load-multiple sequencer. Sequences one word
// read per register, one outstanding at a time, and writes each returned
// word into the register file. Assumes rf_rdata_i is a combinational
// function of rf_raddr_o and that memory answers every request exactly once.
module multi_reg_loader
    import mrl_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 24,
    parameter int          REG_W      = 4,
    parameter int          DISP_W     = 12,
    parameter int          WORD_BYTES = 4,
    parameter logic [7:0]  OPCODE     = 8'h98,
    localparam int         INSTR_W    = 8 + 3 * REG_W + DISP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [REG_W-1:0]   rf_raddr_o,
    input  logic [DATA_W-1:0]  rf_rdata_i,
    output logic               rf_we_o,
    output logic [REG_W-1:0]   rf_waddr_o,
    output logic [DATA_W-1:0]  rf_wdata_o,
    output logic               mem_req_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    input  logic               mem_valid_i,
    input  logic [DATA_W-1:0]  mem_rdata_i
);
    seq_state_t        state;
    logic              done_q;
    logic              accept;
    logic [REG_W-1:0]  first_reg;
    logic [REG_W-1:0]  last_reg;
    logic              base_zero;
    logic [DISP_W-1:0] disp;
    logic              wr_now;
    logic              advance;
    logic              at_final;
    logic [REG_W-1:0]  cur_reg;

    mrl_decode #(
        .REG_W  (REG_W),
        .DISP_W (DISP_W),
        .OPCODE (OPCODE)
    ) u_decode (
        .instr_i     (instr_i),
        .start_i     (start_i),
        .idle_i      (state == ST_IDLE),
        .accept_o    (accept),
        .first_o     (first_reg),
        .last_o      (last_reg),
        .base_sel_o  (rf_raddr_o),
        .base_zero_o (base_zero),
        .disp_o      (disp)
    );

    mrl_addr_gen #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .DISP_W     (DISP_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .base_val_i  (rf_rdata_i),
        .base_zero_i (base_zero),
        .disp_i      (disp),
        .step_i      (advance),
        .addr_o      (mem_addr_o)
    );

    mrl_reg_walker #(
        .REG_W (REG_W)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .first_i (first_reg),
        .last_i  (last_reg),
        .adv_i   (advance),
        .cur_o   (cur_reg),
        .final_o (at_final)
    );

    // Write strobe and advance decision for the current response.
    always_comb begin
        wr_now  = (state == ST_WAIT) && mem_valid_i;
        advance = wr_now && !at_final;
    end

    // Sequencer state and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) state <= ST_REQ;
                ST_REQ:  state <= ST_WAIT;
                ST_WAIT: begin
                    if (wr_now) begin
                        if (at_final) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_REQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        busy_o     = (state != ST_IDLE);
        done_o     = done_q;
        mem_req_o  = (state == ST_REQ);
        rf_we_o    = wr_now;
        rf_waddr_o = cur_reg;
        rf_wdata_o = mem_rdata_i;
    end

    // R7: a request lasts one cycle.
    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);
    // R7: no request in the same cycle as a returned word.
    assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> !mem_req_o);
    // R5: a non-final write is followed by a request one word further on.
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && !at_final) |=>
            (mem_req_o && (mem_addr_o == ADDR_W'($past(mem_addr_o) + WORD_BYTES))));
    // R9: done follows a register write, and busy is already low.
    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rf_we_o) && !busy_o));
    // R1: a foreign opcode while idle does not start a sequence.
    assert_bad_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (instr_i[INSTR_W-1 -: 8] != OPCODE)) |=> !busy_o);
endmodule

// File: tb/multi_reg_loader_bench.sv
// Scoreboard bench: the driver computes expected requests and writes,
// a memory model answers with random latency, a monitor compares.
module multi_reg_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic        busy_o, done_o, rf_we_o, mem_req_o;
    logic [3:0]  rf_raddr_o, rf_waddr_o;
    logic [31:0] rf_rdata_i, rf_wdata_o;
    logic [23:0] mem_addr_o;
    logic        mem_valid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    string cur_tag = "R11";

    logic [31:0] regs [16];
    logic [3:0]  exp_reg_q [$];
    logic [31:0] exp_dat_q [$];
    logic [23:0] exp_adr_q [$];
    bit          done_due = 1'b0;
    bit          outstanding = 1'b0;

    always #4 clk = ~clk;

    multi_reg_loader u_multi_reg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .busy_o(busy_o), .done_o(done_o), .rf_raddr_o(rf_raddr_o),
        .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i)
    );

    assign rf_rdata_i = regs[rf_raddr_o];
    always @(posedge clk) if (rf_we_o) regs[rf_waddr_o] <= rf_wdata_o;

    function automatic logic [31:0] mem_word(logic [23:0] a);
        return {a ^ 24'h3C5A96, a[9:2] ^ 8'hC3};
    endfunction

    function automatic logic [31:0] mk(logic [7:0] op, logic [3:0] f, logic [3:0] l,
                                       logic [3:0] b, logic [11:0] d);
        return {op, f, l, b, d};
    endfunction

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    // Memory model: one answer per request after a random delay.
    initial begin
        logic [23:0] a;
        @(posedge rst_n);
        @(negedge clk);
        forever begin
            #1;
            if (mem_req_o) begin
                a = mem_addr_o;
                repeat (int'($urandom_range(0, 3)) + 1) @(negedge clk);
                mem_rdata_i = mem_word(a);
                mem_valid_i = 1'b1;
                @(negedge clk);
                mem_valid_i = 1'b0;
                mem_rdata_i = '0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // Monitor: compares requests, writes and done against the queues.
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            #2;
            if (done_o || done_due) begin
                check(done_o == done_due, "R9 done pulse", 32'(done_o), 32'(done_due));
                check(!busy_o, "R9 busy low with done", 32'(busy_o), 32'd0);
                if (done_o) done_cnt++;
                done_due = 1'b0;
            end
            if (mem_req_o) begin
                check(!outstanding, "R7 request while outstanding", 32'd1, 32'd0);
                outstanding = 1'b1;
                if (exp_adr_q.size() == 0)
                    check(1'b0, "R4/R5 unexpected request", 32'(mem_addr_o), 32'd0);
                else begin
                    logic [23:0] ea;
                    ea = exp_adr_q.pop_front();
                    check(mem_addr_o == ea, "R4/R5 request address", 32'(mem_addr_o), 32'(ea));
                end
            end
            if (rf_we_o) begin
                outstanding = 1'b0;
                if (exp_reg_q.size() == 0)
                    check(1'b0, "R2 unexpected write", 32'(rf_waddr_o), 32'd0);
                else begin
                    logic [3:0]  er;
                    logic [31:0] ed;
                    er = exp_reg_q.pop_front();
                    ed = exp_dat_q.pop_front();
                    check(rf_waddr_o == er, "R2/R3 write register", 32'(rf_waddr_o), 32'(er));
                    check(rf_wdata_o == ed, "R8 write data", rf_wdata_o, ed);
                    check(rf_wdata_o == mem_rdata_i, "R8 data from memory", rf_wdata_o, mem_rdata_i);
                    if (exp_reg_q.size() == 0) done_due = 1'b1;
                end
            end
        end
    end

    // Driver: pushes the expected traffic, strobes the instruction, waits for done.
    task automatic run(logic [31:0] ins, string tag, bit poke);
        logic [3:0]  f = ins[23:20];
        logic [3:0]  l = ins[19:16];
        logic [3:0]  b = ins[15:12];
        logic [23:0] a0;
        int n = int'(4'(l - f)) + 1;
        int prev = done_cnt;
        cur_tag = tag;
        a0 = (b == 4'd0 ? 24'd0 : regs[b][23:0]) + 24'(ins[11:0]);
        for (int i = 0; i < n; i++) begin
            logic [23:0] a = a0 + 24'(4 * i);
            exp_adr_q.push_back(a);
            exp_reg_q.push_back(4'(f + i));
            exp_dat_q.push_back(mem_word(a));
        end
        @(negedge clk);
        start_i = 1'b1;
        instr_i = ins;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            instr_i = mk(8'h98, 4'd0, 4'd15, 4'd0, 12'h800);
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (done_cnt == prev + 1);
        repeat (6) @(negedge clk);
        check(exp_adr_q.size() == 0 && exp_reg_q.size() == 0,
              "sequence drained", 32'(exp_adr_q.size()), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0000_1100 * i + 32'h40;
        repeat (3) @(negedge clk);
        #2;
        cur_tag = "R11";
        check({busy_o, done_o, mem_req_o, rf_we_o} == 4'b0, "reset outputs",
              32'({busy_o, done_o, mem_req_o, rf_we_o}), 32'd0);
        rst_n = 1'b1;

        regs[3] = 32'h0000_1000;
        run(mk(8'h98, 4'd2, 4'd5, 4'd3, 12'h010), "R2 R4 R5 ascending", 1'b0);
        regs[0] = 32'h0000_7000;
        run(mk(8'h98, 4'd8, 4'd9, 4'd0, 12'hABC), "R4 zero base field", 1'b0);
        run(mk(8'h98, 4'd14, 4'd1, 4'd6, 12'h004), "R3 wrap range", 1'b0);
        run(mk(8'h98, 4'd7, 4'd7, 4'd2, 12'hFFF), "R3 single register", 1'b0);
        regs[5] = 32'h00FF_FFF0;
        run(mk(8'h98, 4'd4, 4'd7, 4'd5, 12'h008), "R6 R5 base in range, 24-bit wrap", 1'b0);
        run(mk(8'h98, 4'd9, 4'd8, 4'd10, 12'h100), "R3 full wrap sixteen", 1'b0);
        run(mk(8'h98, 4'd1, 4'd4, 4'd11, 12'h020), "R10 start while busy", 1'b1);

        cur_tag = "R1";
        @(negedge clk);
        start_i = 1'b1;
        instr_i = mk(8'h18, 4'd1, 4'd3, 4'd1, 12'h000);
        @(negedge clk);
        start_i = 1'b0;
        #2;
        check(!busy_o, "R1 foreign opcode ignored", 32'(busy_o), 32'd0);
        repeat (8) @(negedge clk);
        #2;
        check(!busy_o && !mem_req_o, "R1 still idle", 32'(busy_o), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog %s: actual hung expected done", cur_tag);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule